// File: doc/BRIEF.md
# Voltage and Frequency Transition Sequencer

This block moves a processor core between performance levels by driving two codes: a 5-bit supply code to an external voltage regulator and a frequency code to the clock PLL. A performance level is the frequency code itself. The block looks up the lowest safe supply code for every frequency code. It then orders the two moves so that the core never runs faster than the applied supply allows.

When the level goes up, the supply code climbs one step at a time. Each step settles for a fixed number of timebase ticks. Only after the last step has settled does the frequency code jump to the target. When the level goes down, the frequency code drops first and the block waits for the PLL to report lock. Only then does the supply code walk down, again settling after each step. The core stall output is high only while the block waits for PLL lock. The core keeps running during supply steps.

If lock does not arrive within a bounded number of ticks, the block puts the previous frequency code back, sets an error flag and returns to idle. The load policy that chooses the level sits outside this block.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, `vcode` is 0, `fcode` is 0, and `busy`, `stall` and `lock_err` are all 0.
- R2: Frequency code f (0 to 2^FREQ_W-1, nominally 200 MHz plus about 33 MHz per code) needs at least supply code f*V_PER_F, clamped to 2^VOLT_W-1. Supply code 0 to 31 spans about 1.1 V to 1.6 V.
- R3: On a request above the current level, `vcode` rises by exactly one code per step until it equals the target's minimum supply code, and `fcode` does not change before that.
- R4: On a request below the current level, `fcode` changes first. The block waits for PLL lock, and only then does `vcode` fall one code per step to the target's minimum supply code.
- R5: `fcode` moves straight from its old value to the target in one cycle, and `vcode` and `fcode` never change in the same cycle.
- R6: After every supply step, the block waits SETTLE_TICKS pulses of `tick` before the next step or before raising `fcode`.
- R7: `stall` is 1 from the cycle in which `fcode` takes a requested value until lock is accepted or the wait times out. It is 0 during supply steps and while idle.
- R8: At all times, `vcode` is at least the minimum supply code of the `fcode` being driven.
- R9: If lock is not accepted within LOCK_TICKS pulses of `tick`, `fcode` returns to its previous value, `lock_err` becomes 1 and `busy` drops. With `tick` held high, `stall` is high for exactly LOCK_TICKS cycles. `lock_err` is cleared by the next accepted request that changes the level.
- R10: A request is accepted only while `busy` is 0. A request made while busy is ignored. A request equal to the current `fcode` changes nothing and leaves `busy` at 0. While idle with no request, neither code changes.
- R11: `pll_lock` is ignored in the first cycle of the lock wait, so a PLL that drops lock one cycle late is not mistaken for being locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe for a new target level |
| req_level | input | FREQ_W | Target frequency code |
| tick | input | 1 | Timebase pulse counted by the settle and lock timers |
| pll_lock | input | 1 | PLL lock indication |
| vcode | output | VOLT_W | Supply code to the regulator |
| fcode | output | FREQ_W | Frequency code to the PLL |
| busy | output | 1 | A transition is in progress |
| stall | output | 1 | Core must hold while the PLL relocks |
| lock_err | output | 1 | The last transition timed out waiting for lock |

## Verification
The bench predicts the full ordered list of code moves for each request and matches every move it sees on the outputs against that list. A design that raised frequency before the supply, or dropped the supply before lock, would produce a move out of order. Gaps between supply steps are measured in cycles under both steady and thinned `tick`, which catches a shortened settle. The length of the stall is measured both for a PLL that locks and for one that never does; this catches an early exit or a wrong timeout. A PLL that drops lock one cycle late catches a design that trusts stale lock. Busy-time requests, equal requests, and the recovery path from an error are also exercised.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VSTEP = 2'd1,
        ST_VSET  = 2'd2,
        ST_LOCK  = 2'd3
    } seq_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } move_dir_e;

    // lowest supply code that carries frequency code f
    function automatic int unsigned vf_min_volt(input int unsigned f,
                                                input int unsigned per,
                                                input int unsigned vmax);
        int unsigned v;
        v = f * per;
        return (v > vmax) ? vmax : v;
    endfunction

endpackage

// File: rtl/dvfs_vf_table.sv
module dvfs_vf_table #(
    parameter int FREQ_W  = 4,
    parameter int VOLT_W  = 5,
    parameter int V_PER_F = 2
) (
    input  logic [FREQ_W-1:0] fsel,
    output logic [VOLT_W-1:0] vmin
);
    localparam int NUM_F = 2 ** FREQ_W;
    localparam int VMAX  = (2 ** VOLT_W) - 1;

    logic [VOLT_W-1:0] tbl [NUM_F];

    for (genvar i = 0; i < NUM_F; i++) begin : g_row
        assign tbl[i] = VOLT_W'(dvfs_pkg::vf_min_volt(i, V_PER_F, VMAX));
    end

    assign vmin = tbl[fsel];
endmodule

// File: rtl/dvfs_tick_timer.sv
module dvfs_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    assign done = tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int FREQ_W       = 4,
    parameter int VOLT_W       = 5,
    parameter int V_PER_F      = 2,
    parameter int SETTLE_TICKS = 8,
    parameter int LOCK_TICKS   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [FREQ_W-1:0] req_level,
    input  logic              tick,
    input  logic              pll_lock,
    output logic [VOLT_W-1:0] vcode,
    output logic [FREQ_W-1:0] fcode,
    output logic              busy,
    output logic              stall,
    output logic              lock_err
);
    localparam int TMR_MAX = (SETTLE_TICKS > LOCK_TICKS) ? SETTLE_TICKS : LOCK_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int VMAX    = (2 ** VOLT_W) - 1;
    localparam logic [VOLT_W-1:0] V_RESET = VOLT_W'(vf_min_volt(0, V_PER_F, VMAX));

    seq_state_e        state;
    move_dir_e         dir;
    logic [FREQ_W-1:0] tgt_f, prev_f, fcode_q;
    logic [VOLT_W-1:0] vcode_q, vtgt;
    logic              err_q, armed;
    logic              tmr_clr, tmr_done;
    logic [TMR_W-1:0]  tmr_lim;

    dvfs_vf_table #(
        .FREQ_W (FREQ_W),
        .VOLT_W (VOLT_W),
        .V_PER_F(V_PER_F)
    ) u_table (
        .fsel(tgt_f),
        .vmin(vtgt)
    );

    assign tmr_clr = !(state == ST_VSET || state == ST_LOCK);
    assign tmr_lim = (state == ST_LOCK) ? TMR_W'(LOCK_TICKS) : TMR_W'(SETTLE_TICKS);

    dvfs_tick_timer #(.CNT_W(TMR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clear(tmr_clr),
        .tick (tick),
        .limit(tmr_lim),
        .done (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dir     <= DIR_UP;
            tgt_f   <= '0;
            prev_f  <= '0;
            fcode_q <= '0;
            vcode_q <= V_RESET;
            err_q   <= 1'b0;
            armed   <= 1'b0;
        end else begin
            armed <= (state == ST_LOCK);
            case (state)
                ST_IDLE: begin
                    if (req_valid && req_level != fcode_q) begin
                        err_q  <= 1'b0;
                        tgt_f  <= req_level;
                        prev_f <= fcode_q;
                        if (req_level > fcode_q) begin
                            dir   <= DIR_UP;
                            state <= ST_VSTEP;
                        end else begin
                            dir     <= DIR_DOWN;
                            fcode_q <= req_level;
                            state   <= ST_LOCK;
                        end
                    end
                end
                ST_VSTEP: begin
                    if (dir == DIR_UP) begin
                        if (vcode_q < vtgt) begin
                            vcode_q <= vcode_q + 1'b1;
                            state   <= ST_VSET;
                        end else begin
                            fcode_q <= tgt_f;
                            state   <= ST_LOCK;
                        end
                    end else begin
                        if (vcode_q > vtgt) begin
                            vcode_q <= vcode_q - 1'b1;
                            state   <= ST_VSET;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_VSET: begin
                    if (tmr_done) state <= ST_VSTEP;
                end
                ST_LOCK: begin
                    if (armed && pll_lock) begin
                        state <= (dir == DIR_UP) ? ST_IDLE : ST_VSTEP;
                    end else if (tmr_done) begin
                        fcode_q <= prev_f;
                        err_q   <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign vcode    = vcode_q;
    assign fcode    = fcode_q;
    assign busy     = (state != ST_IDLE);
    assign stall    = (state == ST_LOCK);
    assign lock_err = err_q;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
    parameter int FREQ_W  = 4,
    parameter int VOLT_W  = 5,
    parameter int V_PER_F = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VOLT_W-1:0] vcode,
    input logic [FREQ_W-1:0] fcode,
    input logic              busy,
    input logic              stall
);
    localparam int VMAX = (2 ** VOLT_W) - 1;

    // R8
    freq_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(vcode) >= int'(dvfs_pkg::vf_min_volt(int'(fcode), V_PER_F, VMAX)));

    // R3 R4
    vstep_size_chk: assert property (@(posedge clk) disable iff (rst)
        (vcode != $past(vcode)) |->
        (int'(vcode) == int'($past(vcode)) + 1 || int'(vcode) + 1 == int'($past(vcode))));

    // R5
    split_move_chk: assert property (@(posedge clk) disable iff (rst)
        (fcode != $past(fcode)) |-> (vcode == $past(vcode)));

    // R5
    fjump_once_chk: assert property (@(posedge clk) disable iff (rst)
        (fcode != $past(fcode)) |=> (fcode == $past(fcode)));

    // R7
    stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> busy);

    // R7
    stall_vstep_chk: assert property (@(posedge clk) disable iff (rst)
        (vcode != $past(vcode)) |-> !stall);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> ($stable(vcode) && $stable(fcode)));
endmodule

bind dvfs_seq dvfs_seq_chk #(
    .FREQ_W (FREQ_W),
    .VOLT_W (VOLT_W),
    .V_PER_F(V_PER_F)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .vcode    (vcode),
    .fcode    (fcode),
    .busy     (busy),
    .stall    (stall)
);

// File: tb/dvfs_seq_tb_top.sv
module dvfs_seq_tb_top;
    localparam int FW      = 4;
    localparam int VW      = 5;
    localparam int VPF     = 2;
    localparam int SET     = 6;
    localparam int LOCK_T  = 24;
    localparam int PLL_DLY = 5;

    typedef struct packed {
        logic [VW-1:0] v;
        logic [FW-1:0] f;
        logic          st;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [FW-1:0] req_level = '0;
    logic          tick = 1'b1;
    logic          pll_lock;
    logic [VW-1:0] vcode;
    logic [FW-1:0] fcode;
    logic          busy, stall, lock_err;

    always #4 clk = ~clk;

    dvfs_seq #(
        .FREQ_W(FW), .VOLT_W(VW), .V_PER_F(VPF),
        .SETTLE_TICKS(SET), .LOCK_TICKS(LOCK_T)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .tick(tick), .pll_lock(pll_lock), .vcode(vcode), .fcode(fcode),
        .busy(busy), .stall(stall), .lock_err(lock_err)
    );

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   reported = 0;
    exp_t q[$];

    int            exp_v = 0;
    int            exp_f = 0;
    bit            exp_err = 0;
    bit            pll_dead = 0;
    bit            pll_lag = 0;
    bit            tick_thin = 0;
    int            min_gap = SET;
    int            stall_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int vmin(input int f);
        return (f * VPF > 31) ? 31 : f * VPF;
    endfunction

    // timebase: steady or every other cycle
    always @(negedge clk) tick <= tick_thin ? ~tick : 1'b1;

    // PLL model
    logic [FW-1:0] pll_last;
    int            pll_cnt;
    bit            drop_pend;
    always @(negedge clk) begin
        if (rst) begin
            pll_lock <= 1'b1; pll_last <= '0; pll_cnt <= 0; drop_pend <= 0;
        end else if (fcode != pll_last) begin
            pll_last <= fcode;
            pll_cnt  <= PLL_DLY;
            if (pll_lag) drop_pend <= 1;
            else         pll_lock  <= 1'b0;
        end else if (drop_pend) begin
            pll_lock  <= 1'b0;
            drop_pend <= 0;
        end else if (pll_cnt > 0) begin
            pll_cnt <= pll_cnt - 1;
        end else if (!pll_dead) begin
            pll_lock <= 1'b1;
        end
    end

    // monitor: pops expected moves and compares
    logic [VW-1:0] pv;
    logic [FW-1:0] pf;
    int            last_vchg = -1000;
    exp_t          e;
    always @(negedge clk) begin
        if (rst) begin
            pv = vcode; pf = fcode;
        end else begin
            if (stall) stall_cnt++;
            if (vcode != pv || fcode != pf) begin
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected move (v*100+f)", int'(vcode) * 100 + int'(fcode),
                        int'(pv) * 100 + int'(pf));
                end else begin
                    e = q.pop_front();
                    chk(vcode == e.v, "R3 R4 supply code order", int'(vcode), int'(e.v));
                    chk(fcode == e.f, "R5 frequency code order", int'(fcode), int'(e.f));
                    chk(stall == e.st, "R7 stall at move", int'(stall), int'(e.st));
                end
                chk(int'(vcode) >= vmin(int'(fcode)), "R8 frequency above supply cap",
                    int'(vcode), vmin(int'(fcode)));
                if (vcode != pv) begin
                    chk(cyc - last_vchg >= min_gap, "R6 settle between steps", cyc - last_vchg, min_gap);
                    last_vchg = cyc;
                end else if (fcode > pf) begin
                    chk(cyc - last_vchg >= min_gap, "R6 settle before raise", cyc - last_vchg, min_gap);
                end
            end
            pv = vcode; pf = fcode;
        end
    end

    // driver side: expected moves for one request
    task automatic plan(input int lvl, input bit dead);
        int vt;
        vt = vmin(lvl);
        if (lvl > exp_f) begin
            for (int v = exp_v + 1; v <= vt; v++) q.push_back({VW'(v), FW'(exp_f), 1'b0});
            if (vt > exp_v) exp_v = vt;
            q.push_back({VW'(exp_v), FW'(lvl), 1'b1});
            if (dead) begin
                q.push_back({VW'(exp_v), FW'(exp_f), 1'b0});
                exp_err = 1;
            end else begin
                exp_f = lvl; exp_err = 0;
            end
        end else if (lvl < exp_f) begin
            q.push_back({VW'(exp_v), FW'(lvl), 1'b1});
            if (dead) begin
                q.push_back({VW'(exp_v), FW'(exp_f), 1'b0});
                exp_err = 1;
            end else begin
                for (int v = exp_v - 1; v >= vt; v--) q.push_back({VW'(v), FW'(lvl), 1'b0});
                if (vt < exp_v) exp_v = vt;
                exp_f = lvl; exp_err = 0;
            end
        end
    endtask

    task automatic pulse(input int lvl);
        @(negedge clk);
        req_valid = 1'b1; req_level = FW'(lvl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic end_state(input string tag);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, {tag, " all moves seen"}, q.size(), 0);
        chk(int'(vcode) == exp_v, {tag, " final supply"}, int'(vcode), exp_v);
        chk(int'(fcode) == exp_f, {tag, " final frequency"}, int'(fcode), exp_f);
        chk(lock_err == exp_err, "R9 error flag", int'(lock_err), int'(exp_err));
        chk(!busy, {tag, " busy cleared"}, int'(busy), 0);
    endtask

    task automatic run(input int lvl, input bit dead, input string tag);
        int oldf;
        oldf = exp_f;
        pll_dead = dead;
        plan(lvl, dead);
        stall_cnt = 0;
        pulse(lvl);
        wait_idle();
        end_state(tag);
        if (dead)
            chk(stall_cnt == LOCK_T, "R9 stall length on timeout", stall_cnt, LOCK_T);
        else if (lvl != oldf)
            chk(stall_cnt >= PLL_DLY && stall_cnt < LOCK_T, "R11 R7 stall covers relock",
                stall_cnt, PLL_DLY);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(vcode == 0, "R1 reset supply", int'(vcode), 0);
        chk(fcode == 0, "R1 reset frequency", int'(fcode), 0);
        chk(!busy && !stall && !lock_err, "R1 reset flags",
            int'({busy, stall, lock_err}), 0);

        run(5, 0, "R3 R2 raise to 5");
        run(2, 0, "R4 lower to 2");
        run(15, 0, "R2 raise to top");

        // R10 equal request
        pulse(15);
        chk(!busy, "R10 equal request not busy", int'(busy), 0);
        end_state("R10 equal request");

        run(0, 0, "R4 lower to bottom");

        // R10 request while busy is ignored
        pll_dead = 0;
        plan(3, 0);
        pulse(3);
        repeat (4) @(negedge clk);
        pulse(7);
        wait_idle();
        end_state("R10 busy request ignored");

        // R11 late lock drop
        pll_lag = 1;
        run(6, 0, "R11 late lock drop");
        pll_lag = 0;

        run(8, 1, "R9 raise times out");
        run(8, 0, "R9 retry clears error");
        run(1, 1, "R9 lower times out");
        run(1, 0, "R9 lower retry");

        // R6 thinned timebase
        tick_thin = 1; min_gap = 2 * SET - 1;
        run(11, 0, "R6 thinned tick raise");
        tick_thin = 0; min_gap = SET;

        run(0, 0, "R4 final lower");
        report();
    end
endmodule